// File: doc/BRIEF.md
# Interrupt Request State Tracker

This block keeps the per-line interrupt state for a small interrupt controller that serves a configurable number of request lines. Each line has three state bits: an enable bit, a pending bit and an active bit. The block takes level-held and pulsed sources through the same logic, with no per-line type setting. A level source keeps re-arming its line for as long as it stays asserted. A pulsed source is caught by an edge detector while its handler is running.

The processor sees one request output and the index of the line it should serve. Two single-cycle handshakes, each carrying a line index, mark the start of a handler (acknowledge) and the end of a handler (return). Register-style strobes, one bit per line, let software set or clear the enable bits and set or clear the pending bits. The three state vectors are also brought out so the rest of the controller can read them.

Top module: `irq_state_tracker`

## Requirements
- R1: While a line is not active, a high request input sets its pending bit at the next clock edge, whether or not the line is enabled.
- R2: An acknowledge naming a line sets its active bit and clears its pending bit at the next edge. Two things keep pending set instead: a software set in the same cycle, or a rising edge of the request line in the same cycle.
- R3: While a line is active, a high level alone does not set pending. A low-to-high change of the request input, seen between two consecutive clock samples, sets pending again.
- R4: A return naming a line clears its active bit at the next edge. If the request input is high in that cycle, pending is set.
- R5: `irq_o` is high exactly when no line is active and at least one line is both pending and enabled. A line that became pending while disabled is therefore presented right after its enable is set.
- R6: A set-pending strobe bit sets that line's pending bit at the next edge, as a hardware request would.
- R7: A clear-pending strobe clears the bit only when the line is active or its request input is low. For an inactive line whose input is high, pending stays set.
- R8: When several lines qualify, `irq_id_o` carries the lowest qualifying index while `irq_o` is high.
- R9: A set strobe and a clear strobe on the same line in the same cycle leave the bit set. This holds for enable and for pending.
- R10: An active-low reset clears every enable, pending and active bit and drops `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NCH | Request line per channel, high = asserted |
| en_set_i | input | NCH | Enable set strobes, one bit per line |
| en_clr_i | input | NCH | Enable clear strobes |
| pend_set_i | input | NCH | Pending set strobes |
| pend_clr_i | input | NCH | Pending clear strobes |
| ack_valid_i | input | 1 | Handler entry pulse |
| ack_id_i | input | IDW | Line index of the handler entry |
| ret_valid_i | input | 1 | Handler exit pulse |
| ret_id_i | input | IDW | Line index of the handler exit |
| irq_o | output | 1 | Request toward the processor |
| irq_id_o | output | IDW | Index of the presented line |
| enable_o | output | NCH | Enable bits |
| pending_o | output | NCH | Pending bits |
| active_o | output | NCH | Active bits |

## Verification
The bench drives a held level, then a drop-and-raise pulse while the line's handler runs, then a level still high at handler exit. Together these show whether edge re-arming (R3) and exit re-sampling (R4) are kept separate from plain level latching (R1). Software clears are tried with the line high and then low, which tells an effective clear apart from one that is overridden (R7). Set and clear strobes that collide in one cycle check R9. Several lines made pending under different enables check the disabled-to-enabled presentation and the lowest-index choice (R5, R8). A long stretch of random requests, strobes and handshakes follows, and a behavioural model is compared with the design on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Next pending value for one line, given its current state and this cycle's events.
  function automatic logic pend_next(
    input logic cur,   // current pending
    input logic act,   // current active
    input logic ack,   // handler entry for this line
    input logic ret,   // handler exit for this line
    input logic lvl,   // request line level
    input logic rise,  // request line rising edge
    input logic sset,  // software set
    input logic sclr   // software clear
  );
    logic n;
    n = cur & ~sclr & ~ack;
    n = n | sset;
    n = n | ((act | ack) & rise);
    n = n | (~act & ~ack & lvl);
    n = n | (ret & lvl);
    return n;
  endfunction

  // Next enable value: set beats clear.
  function automatic logic en_next(input logic cur, input logic sset, input logic sclr);
    return sset | (cur & ~sclr);
  endfunction

endpackage

// File: rtl/irq_chan_cell.sv
module irq_chan_cell
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack,
  input  logic ret,
  input  logic en_set,
  input  logic en_clr,
  input  logic pend_set,
  input  logic pend_clr,
  output logic en,
  output logic pend,
  output logic act,
  output logic rise
);

  logic req_q;

  assign rise = req & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      en    <= 1'b0;
      pend  <= 1'b0;
      act   <= 1'b0;
    end else begin
      req_q <= req;
      en    <= en_next(en, en_set, en_clr);
      pend  <= pend_next(pend, act, ack, ret, req, rise, pend_set, pend_clr);
      act   <= ack | (act & ~ret);
    end
  end

endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int NCH = 8,
  parameter int IDW = 3
) (
  input  logic [NCH-1:0] pend,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] act,
  output logic           irq,
  output logic [IDW-1:0] id
);

  logic [NCH-1:0] cand;
  logic           found;

  assign cand = pend & en;

  always_comb begin
    found = 1'b0;
    id    = '0;
    for (int i = 0; i < NCH; i++) begin
      if (!found && cand[i]) begin
        id    = IDW'(i);
        found = 1'b1;
      end
    end
  end

  assign irq = found & ~(|act);

endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
  parameter int NCH = 8,
  localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] en_set_i,
  input  logic [NCH-1:0] en_clr_i,
  input  logic [NCH-1:0] pend_set_i,
  input  logic [NCH-1:0] pend_clr_i,
  input  logic           ack_valid_i,
  input  logic [IDW-1:0] ack_id_i,
  input  logic           ret_valid_i,
  input  logic [IDW-1:0] ret_id_i,
  output logic           irq_o,
  output logic [IDW-1:0] irq_id_o,
  output logic [NCH-1:0] enable_o,
  output logic [NCH-1:0] pending_o,
  output logic [NCH-1:0] active_o
);

  // Decoded per-line events, named for the checker.
  logic [NCH-1:0] ack_hit;
  logic [NCH-1:0] ret_hit;
  logic [NCH-1:0] rise_hit;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign ack_hit[k] = ack_valid_i && (ack_id_i == IDW'(k));
    assign ret_hit[k] = ret_valid_i && (ret_id_i == IDW'(k));

    irq_chan_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_i[k]),
      .ack      (ack_hit[k]),
      .ret      (ret_hit[k]),
      .en_set   (en_set_i[k]),
      .en_clr   (en_clr_i[k]),
      .pend_set (pend_set_i[k]),
      .pend_clr (pend_clr_i[k]),
      .en       (enable_o[k]),
      .pend     (pending_o[k]),
      .act      (active_o[k]),
      .rise     (rise_hit[k])
    );
  end

  irq_select #(.NCH(NCH), .IDW(IDW)) u_sel (
    .pend (pending_o),
    .en   (enable_o),
    .act  (active_o),
    .irq  (irq_o),
    .id   (irq_id_o)
  );

endmodule

// File: rtl/irq_tracker_chk.sv
module irq_tracker_chk #(
  parameter int NCH = 8,
  parameter int IDW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req_i,
  input logic [NCH-1:0] en_set_i,
  input logic [NCH-1:0] pend_set_i,
  input logic [NCH-1:0] ack_hit,
  input logic [NCH-1:0] ret_hit,
  input logic [NCH-1:0] rise_hit,
  input logic           irq_o,
  input logic [IDW-1:0] irq_id_o,
  input logic [NCH-1:0] enable_o,
  input logic [NCH-1:0] pending_o,
  input logic [NCH-1:0] active_o
);

  for (genvar k = 0; k < NCH; k++) begin : g_a
    assert_level_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_o[k] && req_i[k] && !ack_hit[k]) |=> pending_o[k]);
    assert_entry_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit[k] |=> active_o[k]);
    assert_edge_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o[k] && rise_hit[k]) |=> pending_o[k]);
    assert_exit_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_hit[k] && !ack_hit[k]) |=> !active_o[k]);
    assert_exit_resample_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_hit[k] && req_i[k]) |=> pending_o[k]);
    assert_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pend_set_i[k] |=> pending_o[k]);
    assert_en_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      en_set_i[k] |=> enable_o[k]);
  end

  assert_no_nesting_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (active_o == '0));
  assert_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((active_o == '0) && ((pending_o & enable_o) != '0)) |-> irq_o);
  assert_id_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pending_o[irq_id_o] && enable_o[irq_id_o]));
  assert_id_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pending_o & enable_o & ((NCH'(1) << irq_id_o) - NCH'(1))) == '0));

endmodule

bind irq_state_tracker irq_tracker_chk #(.NCH(NCH), .IDW(IDW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .en_set_i   (en_set_i),
  .pend_set_i (pend_set_i),
  .ack_hit    (ack_hit),
  .ret_hit    (ret_hit),
  .rise_hit   (rise_hit),
  .irq_o      (irq_o),
  .irq_id_o   (irq_id_o),
  .enable_o   (enable_o),
  .pending_o  (pending_o),
  .active_o   (active_o)
);

// File: tb/sim_irq_state_tracker.sv
module sim_irq_state_tracker;
  localparam int NCH = 8;
  localparam int IDW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] req_i = '0, en_set_i = '0, en_clr_i = '0, pend_set_i = '0, pend_clr_i = '0;
  logic ack_valid_i = 1'b0, ret_valid_i = 1'b0;
  logic [IDW-1:0] ack_id_i = '0, ret_id_i = '0;
  logic irq_o;
  logic [IDW-1:0] irq_id_o;
  logic [NCH-1:0] enable_o, pending_o, active_o;

  always #10 clk = ~clk;

  irq_state_tracker u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .pend_set_i(pend_set_i), .pend_clr_i(pend_clr_i), .ack_valid_i(ack_valid_i),
    .ack_id_i(ack_id_i), .ret_valid_i(ret_valid_i), .ret_id_i(ret_id_i),
    .irq_o(irq_o), .irq_id_o(irq_id_o), .enable_o(enable_o), .pending_o(pending_o),
    .active_o(active_o)
  );

  // Behavioural reference model
  bit m_en[NCH], m_pd[NCH], m_ac[NCH], m_prev[NCH];
  int n_cmp = 0, n_bad = 0;
  string phase = "R10 reset";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_en[i]) begin m_en[i] = 0; m_pd[i] = 0; m_ac[i] = 0; m_prev[i] = 0; end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        bit entry, leave, lvl, up, keep, nxt;
        entry = ack_valid_i && (int'(ack_id_i) == i);
        leave = ret_valid_i && (int'(ret_id_i) == i);
        lvl   = req_i[i];
        up    = lvl && !m_prev[i];
        keep  = m_pd[i] && !pend_clr_i[i] && !entry;
        if (pend_set_i[i]) nxt = 1;
        else if (m_ac[i] || entry) nxt = keep || up || (leave && lvl);
        else nxt = keep || lvl;
        m_pd[i] = nxt;
        if (en_set_i[i]) m_en[i] = 1;
        else if (en_clr_i[i]) m_en[i] = 0;
        if (entry) m_ac[i] = 1;
        else if (leave) m_ac[i] = 0;
        m_prev[i] = lvl;
      end
    end
  end

  task automatic compare();
    logic [NCH-1:0] e_en, e_pd, e_ac;
    logic e_irq;
    int e_id;
    bit any_act;
    e_id = -1; any_act = 0;
    for (int i = 0; i < NCH; i++) begin
      e_en[i] = m_en[i]; e_pd[i] = m_pd[i]; e_ac[i] = m_ac[i];
      if (m_ac[i]) any_act = 1;
      if (e_id < 0 && m_en[i] && m_pd[i]) e_id = i;
    end
    e_irq = (e_id >= 0) && !any_act;
    n_cmp++;
    if (enable_o !== e_en || pending_o !== e_pd || active_o !== e_ac || irq_o !== e_irq ||
        (e_irq && int'(irq_id_o) != e_id)) begin
      n_bad++;
      $display("FAIL %s: en=%h pd=%h ac=%h irq=%b id=%0d expected en=%h pd=%h ac=%h irq=%b id=%0d",
               phase, enable_o, pending_o, active_o, irq_o, irq_id_o, e_en, e_pd, e_ac, e_irq, e_id);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    en_set_i = '0; en_clr_i = '0; pend_set_i = '0; pend_clr_i = '0;
    ack_valid_i = 1'b0; ret_valid_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();                      // R10: state cleared during reset
    rst_n = 1'b1;
    ticks(2);
    phase = "R1 level latch while disabled";
    req_i = 8'h04; ticks(3);
    phase = "R5 enable presents pending";
    en_set_i = 8'h04; ticks(2);
    phase = "R8 lowest index";
    req_i = req_i | 8'h20; en_set_i = 8'h20; tick();
    req_i = req_i | 8'h01; en_set_i = 8'h01; ticks(2);
    phase = "R2 handler entry";
    ack_valid_i = 1'b1; ack_id_i = 3'd0; ticks(2);
    phase = "R3 edge while active";
    req_i = req_i & ~8'h01; tick();
    req_i = req_i | 8'h01; ticks(2);
    phase = "R4 return resamples";
    ret_valid_i = 1'b1; ret_id_i = 3'd0; ticks(2);
    ack_valid_i = 1'b1; ack_id_i = 3'd0; tick();
    req_i = req_i & ~8'h01; tick();
    ret_valid_i = 1'b1; ret_id_i = 3'd0; ticks(2);
    phase = "R7 clear blocked by level";
    pend_clr_i = 8'h04; ticks(2);
    req_i = req_i & ~8'h04; pend_clr_i = 8'h04; tick();
    phase = "R7 clear effective";
    ticks(2);
    phase = "R6 software set";
    pend_set_i = 8'h80; ticks(2);
    phase = "R9 set beats clear";
    pend_set_i = 8'h40; pend_clr_i = 8'h40; en_set_i = 8'h40; en_clr_i = 8'h40; ticks(2);
    phase = "R5 disable hides";
    en_clr_i = 8'hFF; ticks(2);
    phase = "mixed R1 R2 R3 R4 R6 R7 R8 R9";
    for (int c = 0; c < 3000; c++) begin
      logic [NCH-1:0] flip;
      flip = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      req_i = req_i ^ flip;
      if ($urandom_range(0, 3) == 0) en_set_i = NCH'($urandom);
      if ($urandom_range(0, 5) == 0) en_clr_i = NCH'($urandom);
      if ($urandom_range(0, 7) == 0) pend_set_i = NCH'($urandom) & NCH'($urandom);
      if ($urandom_range(0, 5) == 0) pend_clr_i = NCH'($urandom);
      if (irq_o && $urandom_range(0, 1) == 0) begin
        ack_valid_i = 1'b1; ack_id_i = irq_id_o;
      end else if (active_o != '0 && $urandom_range(0, 3) == 0) begin
        for (int i = 0; i < NCH; i++) if (active_o[i]) ret_id_i = IDW'(i);
        ret_valid_i = 1'b1;
      end
      tick();
    end
    phase = "R10 reset again";
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); compare();
    rst_n = 1'b1; req_i = '0;
    ticks(2);
    finish_run();
  end

endmodule